// File: doc/BRIEF.md
# Two-Sided Doorbell Mailbox

This block joins two agents, a host side and a guest side, through a pair of small message buffers and a valid/acknowledge doorbell. Each side owns a register port with a 32-bit read/write bus and byte enables. A side composes a message in its four transmit words and then raises its transmit-valid flag. The other side sees the flag as receive-valid, reads the message through a read-only window onto the sender's transmit words, and acknowledges it. The acknowledge then shows up as a read-only status bit in the sender's control register.

The acknowledge is torn down as a chain. When the sender withdraws valid, its visible acknowledge status drops at once. On the next clock edge the receiver's acknowledge flag is cleared. An acknowledge left over from an earlier exchange therefore cannot answer a poll for a newly posted message. Each side has two level interrupts: message arrived and message acknowledged. Each one has its own enable bit.

Top module: `doorbell_mailbox`

## Requirements
- R1: Each side decodes word offsets on its `*_addr` port as follows. Offsets 0 to 3 are its own transmit words, readable and writable. Offsets 4 to 7 are the receive window. Offset 8 is control and offset 9 is interrupt enable. Any other offset reads as zero, and a write to it has no effect. Reads are combinational from the address.
- R2: Control bit 0 (byte lane 0) is transmit-valid. A write with lane 0 enabled loads that bit: 1 posts a message and 0 withdraws it.
- R3: Control bit 1 is the transmit-acknowledge status. It reads as the peer's receive-acknowledge flag ANDed with this side's transmit-valid. Writes to it have no effect.
- R4: Control bit 8 is receive-valid and reads the peer's transmit-valid. Control bit 9 is the receive-acknowledge flag. A write with lane 1 enabled and bit 9 set (value 0x200) sets the flag, but only while receive-valid is 1. Writing 0 to bit 9, or acknowledging with no message posted, leaves the flag at 0 or unchanged.
- R5: At every clock edge the receive-acknowledge flag takes the value receive-valid AND (flag OR acknowledge write), using the values before the edge. When the sender drops valid, its transmit-acknowledge status reads 0 in the same cycle, and the receiver's flag reads 0 one edge later.
- R6: Receive words 4 to 7 read the peer's transmit words 0 to 3 in the same order. Writes to these offsets have no effect on either side.
- R7: Interrupt-enable bit 0 enables the acknowledge interrupt and bit 1 enables the message interrupt. Both are written through byte lane 0.
- R8: `*_irq_msg` is high exactly while the message enable and receive-valid are both 1. `*_irq_ack` is high exactly while the acknowledge enable and transmit-acknowledge status are both 1.
- R9: The synchronous reset clears all words, flags and enables to zero.
- R10: A write to a transmit word updates only the byte lanes whose `*_be` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_we | input | 1 | Host write strobe |
| h_be | input | 4 | Host byte enables |
| h_addr | input | 4 | Host word offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data |
| h_irq_msg | output | 1 | Host message-arrived interrupt |
| h_irq_ack | output | 1 | Host message-acknowledged interrupt |
| g_we | input | 1 | Guest write strobe |
| g_be | input | 4 | Guest byte enables |
| g_addr | input | 4 | Guest word offset |
| g_wdata | input | 32 | Guest write data |
| g_rdata | output | 32 | Guest read data |
| g_irq_msg | output | 1 | Guest message-arrived interrupt |
| g_irq_ack | output | 1 | Guest message-acknowledged interrupt |

## Verification
The hardest case to reach is a stale acknowledge. It needs a sender that withdraws valid and posts again on the very next cycle, while the receiver's flag from the old exchange has not yet been cleared. The directed part of the stimulus sets up this back-to-back withdraw and re-post. It also acknowledges with no message posted and in the same cycle as a withdrawal. After that, a long run of random writes from both sides hits control and enable registers often, so the two directions overlap in many orders. A behavioural model is compared against every read and every interrupt level on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // Control register bit positions (neighbouring software decodes them)
   localparam int CTRL_TXV   = 0;
   localparam int CTRL_TXACK = 1;
   localparam int CTRL_RXV   = 8;
   localparam int CTRL_RXACK = 9;
   // Interrupt-enable register bit positions
   localparam int IEN_ACK    = 0;
   localparam int IEN_MSG    = 1;
   // Side indices
   localparam int SIDE_HOST  = 0;
   localparam int SIDE_GUEST = 1;
   localparam int NUM_SIDES  = 2;
endpackage

// File: rtl/mbx_side_regs.sv
module mbx_side_regs
   import mbx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 4,
   parameter int ADDR_W    = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        we,
   input  logic [DATA_W/8-1:0]         be,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           wdata,
   input  logic                        peer_valid,
   output logic [NUM_WORDS*DATA_W-1:0] tx_words_o,
   output logic                        tx_valid_o,
   output logic                        rx_ack_o,
   output logic                        ack_en_o,
   output logic                        msg_en_o
);
   localparam int LANES = DATA_W / 8;
   localparam logic [ADDR_W-1:0] CTRL_IDX = ADDR_W'(2 * NUM_WORDS);
   localparam logic [ADDR_W-1:0] IEN_IDX  = ADDR_W'(2 * NUM_WORDS + 1);
   localparam int TXV_LANE   = CTRL_TXV / 8;
   localparam int RXACK_LANE = CTRL_RXACK / 8;

   logic ctrl_wr, ien_wr, ack_wr;
   logic tx_valid_q, rx_ack_q, ack_en_q, msg_en_q;

   assign ctrl_wr = we && (addr == CTRL_IDX);
   assign ien_wr  = we && (addr == IEN_IDX);
   assign ack_wr  = ctrl_wr && be[RXACK_LANE] && wdata[CTRL_RXACK];

   // Transmit words with per-lane write enables (R10)
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            word_q <= '0;
         end else if (we && (addr == ADDR_W'(w))) begin
            for (int l = 0; l < LANES; l++) begin
               if (be[l]) word_q[l*8 +: 8] <= wdata[l*8 +: 8];
            end
         end
      end
      assign tx_words_o[w*DATA_W +: DATA_W] = word_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_valid_q <= 1'b0;
         rx_ack_q   <= 1'b0;
         ack_en_q   <= 1'b0;
         msg_en_q   <= 1'b0;
      end else begin
         if (ctrl_wr && be[TXV_LANE]) tx_valid_q <= wdata[CTRL_TXV];
         // acknowledge survives only while the peer still posts
         rx_ack_q <= peer_valid && (rx_ack_q || ack_wr);
         if (ien_wr && be[0]) begin
            ack_en_q <= wdata[IEN_ACK];
            msg_en_q <= wdata[IEN_MSG];
         end
      end
   end

   assign tx_valid_o = tx_valid_q;
   assign rx_ack_o   = rx_ack_q;
   assign ack_en_o   = ack_en_q;
   assign msg_en_o   = msg_en_q;

   // R2: a lane-0 control write loads transmit-valid
   p_valid_load_r2: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr && be[TXV_LANE]) |=> (tx_valid_o == $past(wdata[CTRL_TXV])));
   // R4: acknowledge while a message is posted sets the flag
   p_ack_set_r4: assert property (@(posedge clk) disable iff (rst)
      (ack_wr && peer_valid) |=> rx_ack_o);
   // R4: no flag without an acknowledge write
   p_no_spurious_ack_r4: assert property (@(posedge clk) disable iff (rst)
      (!rx_ack_o && !ack_wr) |=> !rx_ack_o);
   // R5: withdrawn peer message clears the flag one edge later
   p_ack_chain_r5: assert property (@(posedge clk) disable iff (rst)
      !peer_valid |=> !rx_ack_o);
   // R5: flag holds while the peer keeps posting
   p_ack_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (rx_ack_o && peer_valid) |=> rx_ack_o);
endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux
   import mbx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 4,
   parameter int ADDR_W    = 4
) (
   input  logic [ADDR_W-1:0]           addr,
   input  logic [NUM_WORDS*DATA_W-1:0] tx_words,
   input  logic [NUM_WORDS*DATA_W-1:0] rx_words,
   input  logic                        tx_valid,
   input  logic                        tx_ack,
   input  logic                        rx_valid,
   input  logic                        rx_ack,
   input  logic                        ack_en,
   input  logic                        msg_en,
   output logic [DATA_W-1:0]           rdata
);
   localparam logic [ADDR_W-1:0] CTRL_IDX = ADDR_W'(2 * NUM_WORDS);
   localparam logic [ADDR_W-1:0] IEN_IDX  = ADDR_W'(2 * NUM_WORDS + 1);

   always_comb begin
      rdata = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (addr == ADDR_W'(w))             rdata = tx_words[w*DATA_W +: DATA_W];
         if (addr == ADDR_W'(NUM_WORDS + w)) rdata = rx_words[w*DATA_W +: DATA_W];
      end
      if (addr == CTRL_IDX) begin
         rdata[CTRL_TXV]   = tx_valid;
         rdata[CTRL_TXACK] = tx_ack;
         rdata[CTRL_RXV]   = rx_valid;
         rdata[CTRL_RXACK] = rx_ack;
      end
      if (addr == IEN_IDX) begin
         rdata[IEN_ACK] = ack_en;
         rdata[IEN_MSG] = msg_en;
      end
   end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen (
   input  logic msg_en,
   input  logic ack_en,
   input  logic rx_valid,
   input  logic tx_ack,
   output logic irq_msg,
   output logic irq_ack
);
   assign irq_msg = msg_en && rx_valid;
   assign irq_ack = ack_en && tx_ack;
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
   import mbx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 4,
   parameter int ADDR_W    = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                h_we,
   input  logic [DATA_W/8-1:0] h_be,
   input  logic [ADDR_W-1:0]   h_addr,
   input  logic [DATA_W-1:0]   h_wdata,
   output logic [DATA_W-1:0]   h_rdata,
   output logic                h_irq_msg,
   output logic                h_irq_ack,
   input  logic                g_we,
   input  logic [DATA_W/8-1:0] g_be,
   input  logic [ADDR_W-1:0]   g_addr,
   input  logic [DATA_W-1:0]   g_wdata,
   output logic [DATA_W-1:0]   g_rdata,
   output logic                g_irq_msg,
   output logic                g_irq_ack
);
   localparam int LANES  = DATA_W / 8;
   localparam int BUF_W  = NUM_WORDS * DATA_W;
   localparam int MAP_SZ = 2 * NUM_WORDS + 2;

   if (DATA_W % 8 != 0 || DATA_W < CTRL_RXACK + 1) begin : g_bad_width
      $error("DATA_W must be a byte multiple wide enough for the control bits");
   end
   if (MAP_SZ > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (NUM_WORDS < 1) begin : g_bad_depth
      $error("NUM_WORDS must be at least 1");
   end

   logic               we_s     [NUM_SIDES];
   logic [LANES-1:0]   be_s     [NUM_SIDES];
   logic [ADDR_W-1:0]  addr_s   [NUM_SIDES];
   logic [DATA_W-1:0]  wdata_s  [NUM_SIDES];
   logic [DATA_W-1:0]  rdata_s  [NUM_SIDES];
   logic [BUF_W-1:0]   words_s  [NUM_SIDES];
   logic               valid_s  [NUM_SIDES];
   logic               rxack_s  [NUM_SIDES];
   logic               txack_s  [NUM_SIDES];
   logic               acken_s  [NUM_SIDES];
   logic               msgen_s  [NUM_SIDES];
   logic               irqm_s   [NUM_SIDES];
   logic               irqa_s   [NUM_SIDES];

   assign we_s[SIDE_HOST]    = h_we;
   assign be_s[SIDE_HOST]    = h_be;
   assign addr_s[SIDE_HOST]  = h_addr;
   assign wdata_s[SIDE_HOST] = h_wdata;
   assign we_s[SIDE_GUEST]    = g_we;
   assign be_s[SIDE_GUEST]    = g_be;
   assign addr_s[SIDE_GUEST]  = g_addr;
   assign wdata_s[SIDE_GUEST] = g_wdata;

   assign h_rdata   = rdata_s[SIDE_HOST];
   assign h_irq_msg = irqm_s[SIDE_HOST];
   assign h_irq_ack = irqa_s[SIDE_HOST];
   assign g_rdata   = rdata_s[SIDE_GUEST];
   assign g_irq_msg = irqm_s[SIDE_GUEST];
   assign g_irq_ack = irqa_s[SIDE_GUEST];

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      localparam int P = NUM_SIDES - 1 - s;

      mbx_side_regs #(
         .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)
      ) regs_i (
         .clk        (clk),
         .rst        (rst),
         .we         (we_s[s]),
         .be         (be_s[s]),
         .addr       (addr_s[s]),
         .wdata      (wdata_s[s]),
         .peer_valid (valid_s[P]),
         .tx_words_o (words_s[s]),
         .tx_valid_o (valid_s[s]),
         .rx_ack_o   (rxack_s[s]),
         .ack_en_o   (acken_s[s]),
         .msg_en_o   (msgen_s[s])
      );

      // sender's visible acknowledge mirrors the receiver's flag
      assign txack_s[s] = rxack_s[P] && valid_s[s];

      mbx_rd_mux #(
         .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)
      ) mux_i (
         .addr     (addr_s[s]),
         .tx_words (words_s[s]),
         .rx_words (words_s[P]),
         .tx_valid (valid_s[s]),
         .tx_ack   (txack_s[s]),
         .rx_valid (valid_s[P]),
         .rx_ack   (rxack_s[s]),
         .ack_en   (acken_s[s]),
         .msg_en   (msgen_s[s]),
         .rdata    (rdata_s[s])
      );

      mbx_irq_gen irq_i (
         .msg_en   (msgen_s[s]),
         .ack_en   (acken_s[s]),
         .rx_valid (valid_s[P]),
         .tx_ack   (txack_s[s]),
         .irq_msg  (irqm_s[s]),
         .irq_ack  (irqa_s[s])
      );

      // R3: an acknowledge status needs a message posted on the previous cycle
      p_txack_needs_post_r3: assert property (@(posedge clk) disable iff (rst)
         txack_s[s] |-> $past(valid_s[s]));
      // R8: message interrupt drops with the peer's withdrawal
      p_msg_irq_drop_r8: assert property (@(posedge clk) disable iff (rst)
         $fell(valid_s[P]) |-> !irqm_s[s]);
      // R5: sender's acknowledge interrupt drops as soon as it withdraws
      p_ack_irq_drop_r5: assert property (@(posedge clk) disable iff (rst)
         $fell(valid_s[s]) |-> !irqa_s[s]);
   end
endmodule

// File: tb/doorbell_mailbox_tb.sv
module doorbell_mailbox_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        we_d   [2];
   logic [3:0]  be_d   [2];
   logic [3:0]  addr_d [2];
   logic [31:0] wdat_d [2];
   logic [31:0] h_rdata, g_rdata;
   logic        h_irq_msg, h_irq_ack, g_irq_msg, g_irq_ack;

   doorbell_mailbox dut_i (
      .clk(clk), .rst(rst),
      .h_we(we_d[0]), .h_be(be_d[0]), .h_addr(addr_d[0]), .h_wdata(wdat_d[0]),
      .h_rdata(h_rdata), .h_irq_msg(h_irq_msg), .h_irq_ack(h_irq_ack),
      .g_we(we_d[1]), .g_be(be_d[1]), .g_addr(addr_d[1]), .g_wdata(wdat_d[1]),
      .g_rdata(g_rdata), .g_irq_msg(g_irq_msg), .g_irq_ack(g_irq_ack)
   );

   // behavioural reference state
   logic [31:0] m_tx  [2][4];
   bit          m_val [2];
   bit          m_ack [2];
   bit          m_aen [2];
   bit          m_men [2];

   int    checks = 0;
   int    errors = 0;
   string phase  = "R9";
   bit    done   = 0;

   function automatic logic [31:0] exp_rd(int s, logic [3:0] a);
      int p = 1 - s;
      logic [31:0] v = '0;
      if (a < 4)       v = m_tx[s][a];
      else if (a < 8)  v = m_tx[p][a-4];
      else if (a == 8) begin
         v[0] = m_val[s];
         v[1] = m_ack[p] & m_val[s];
         v[8] = m_val[p];
         v[9] = m_ack[s];
      end else if (a == 9) begin
         v[0] = m_aen[s];
         v[1] = m_men[s];
      end
      return v;
   endfunction

   function automatic string addr_tag(logic [3:0] a);
      if (a < 4)  return "R1";
      if (a < 8)  return "R6";
      if (a == 8) return "R5";
      if (a == 9) return "R7";
      return "R1";
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s/%s: actual %08h expected %08h at %0t", phase, tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      logic [31:0] ntx [2][4];
      bit nval [2], nack [2], naen [2], nmen [2];
      for (int s = 0; s < 2; s++) begin
         int p = 1 - s;
         bit ackw = 0;
         for (int w = 0; w < 4; w++) ntx[s][w] = m_tx[s][w];
         nval[s] = m_val[s]; naen[s] = m_aen[s]; nmen[s] = m_men[s];
         if (we_d[s]) begin
            if (addr_d[s] < 4) begin
               for (int l = 0; l < 4; l++)
                  if (be_d[s][l]) ntx[s][addr_d[s]][l*8 +: 8] = wdat_d[s][l*8 +: 8];
            end else if (addr_d[s] == 8) begin
               if (be_d[s][0]) nval[s] = wdat_d[s][0];
               ackw = be_d[s][1] && wdat_d[s][9];
            end else if (addr_d[s] == 9 && be_d[s][0]) begin
               naen[s] = wdat_d[s][0];
               nmen[s] = wdat_d[s][1];
            end
         end
         nack[s] = m_val[p] && (m_ack[s] || ackw);
      end
      for (int s = 0; s < 2; s++) begin
         for (int w = 0; w < 4; w++) m_tx[s][w] = ntx[s][w];
         m_val[s] = nval[s]; m_ack[s] = nack[s];
         m_aen[s] = naen[s]; m_men[s] = nmen[s];
      end
   endtask

   // one clock: drive at negedge, compare just after, advance model
   task automatic cyc(logic hw, logic [3:0] hb, logic [3:0] ha, logic [31:0] hd,
                      logic gw, logic [3:0] gb, logic [3:0] ga, logic [31:0] gd);
      @(negedge clk);
      we_d[0] = hw; be_d[0] = hb; addr_d[0] = ha; wdat_d[0] = hd;
      we_d[1] = gw; be_d[1] = gb; addr_d[1] = ga; wdat_d[1] = gd;
      #1;
      chk(addr_tag(ha), h_rdata, exp_rd(0, ha));
      chk(addr_tag(ga), g_rdata, exp_rd(1, ga));
      chk("R8", {31'b0, h_irq_msg}, {31'b0, m_men[0] & m_val[1]});
      chk("R8", {31'b0, g_irq_msg}, {31'b0, m_men[1] & m_val[0]});
      chk("R8", {31'b0, h_irq_ack}, {31'b0, m_aen[0] & m_ack[1] & m_val[0]});
      chk("R8", {31'b0, g_irq_ack}, {31'b0, m_aen[1] & m_ack[0] & m_val[1]});
      model_step();
   endtask

   task automatic rd(logic [3:0] ha, logic [3:0] ga);
      cyc(1'b0, 4'h0, ha, 32'h0, 1'b0, 4'h0, ga, 32'h0);
   endtask

   initial begin
      repeat (CLK_PERIOD * 200000) #1;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < 2; s++) begin
         we_d[s] = 0; be_d[s] = 0; addr_d[s] = 0; wdat_d[s] = 0;
         for (int w = 0; w < 4; w++) m_tx[s][w] = '0;
         m_val[s] = 0; m_ack[s] = 0; m_aen[s] = 0; m_men[s] = 0;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R9: reset state, every offset including unmapped ones
      phase = "R9";
      for (int a = 0; a < 16; a++) rd(4'(a), 4'(15 - a));

      // R10: byte-lane writes into host transmit words
      phase = "R10";
      cyc(1, 4'hF, 4'd0, 32'h1111_1111, 0, 0, 4'd4, 0);
      cyc(1, 4'h5, 4'd1, 32'hAABB_CCDD, 0, 0, 4'd5, 0);
      cyc(1, 4'hA, 4'd2, 32'h1234_5678, 0, 0, 4'd6, 0);
      cyc(1, 4'h8, 4'd3, 32'hDEAD_BEEF, 1, 4'hF, 4'd3, 32'h0000_00C3);
      cyc(1, 4'hF, 4'd12, 32'hFFFF_FFFF, 0, 0, 4'd12, 0);
      for (int a = 0; a < 4; a++) rd(4'(a), 4'(a + 4));

      // R6: guest writes to its receive window are ignored
      phase = "R6";
      cyc(0, 0, 4'd0, 0, 1, 4'hF, 4'd4, 32'h5555_5555);
      cyc(0, 0, 4'd4, 0, 1, 4'hF, 4'd7, 32'h6666_6666);
      rd(4'd0, 4'd4);
      rd(4'd3, 4'd7);

      // R7: enable both interrupts on both sides, partial-lane miss first
      phase = "R7";
      cyc(1, 4'h2, 4'd9, 32'h3, 1, 4'hE, 4'd9, 32'h3);
      rd(4'd9, 4'd9);
      cyc(1, 4'h1, 4'd9, 32'h3, 1, 4'h1, 4'd9, 32'h3);
      rd(4'd9, 4'd9);

      // R4: acknowledge with nothing posted is dropped
      phase = "R4";
      cyc(0, 0, 4'd8, 0, 1, 4'h2, 4'd8, 32'h200);
      rd(4'd8, 4'd8);

      // R2/R3: post a message, try to force the read-only ack status
      phase = "R2";
      cyc(1, 4'h1, 4'd8, 32'h3, 0, 0, 4'd8, 0);
      rd(4'd8, 4'd8);
      phase = "R3";
      rd(4'd8, 4'd8);

      // R4: guest writes 0 to bit 9 (no effect) then acknowledges
      phase = "R4";
      cyc(0, 0, 4'd8, 0, 1, 4'h2, 4'd8, 32'h0);
      rd(4'd8, 4'd8);
      cyc(0, 0, 4'd8, 0, 1, 4'h2, 4'd8, 32'h200);
      rd(4'd8, 4'd8);
      rd(4'd8, 4'd8);

      // R5: withdraw, then re-post at once: stale ack must not appear
      phase = "R5";
      cyc(1, 4'h1, 4'd8, 32'h0, 0, 0, 4'd8, 0);
      cyc(1, 4'h1, 4'd8, 32'h1, 0, 0, 4'd8, 0);
      rd(4'd8, 4'd8);
      rd(4'd8, 4'd8);
      // ack in the same cycle as the withdrawal
      cyc(1, 4'h1, 4'd8, 32'h0, 1, 4'h2, 4'd8, 32'h200);
      rd(4'd8, 4'd8);
      rd(4'd8, 4'd8);

      // R8: reverse direction with the host's message interrupt masked
      phase = "R8";
      cyc(1, 4'h1, 4'd9, 32'h1, 1, 4'h1, 4'd8, 32'h1);
      rd(4'd8, 4'd8);
      cyc(1, 4'h2, 4'd8, 32'h200, 0, 0, 4'd8, 0);
      rd(4'd8, 4'd8);
      cyc(1, 4'h1, 4'd9, 32'h3, 0, 0, 4'd8, 0);
      cyc(0, 0, 4'd8, 0, 1, 4'h1, 4'd9, 32'h2);
      rd(4'd8, 4'd8);
      cyc(0, 0, 4'd8, 0, 1, 4'h1, 4'd8, 32'h0);
      rd(4'd8, 4'd8);

      // random traffic from both sides
      phase = "R1";
      for (int i = 0; i < 3000; i++) begin
         logic [3:0]  ha = 4'($urandom_range(0, 10));
         logic [3:0]  ga = 4'($urandom_range(0, 10));
         logic [31:0] hd = $urandom;
         logic [31:0] gd = $urandom;
         if ($urandom_range(0, 2) == 0) ha = 4'd8;
         if ($urandom_range(0, 2) == 0) ga = 4'd8;
         cyc(1'($urandom_range(0, 1)), 4'($urandom), ha, hd,
             1'($urandom_range(0, 1)), 4'($urandom), ga, gd);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule